// File: doc/BRIEF.md
# Global 64-bit Comparator Timer

This block is a free-running 64-bit up-counter with four compare channels. Software reaches it through a 32-bit read/write register port. Each channel holds a 64-bit compare value. When an enabled channel sees the counter equal to its value, the channel latches a status bit. That bit drives the channel's interrupt line if the matching interrupt enable is set. Any channel can also rearm itself: on each match it adds a programmed 32-bit step to its own compare value, which gives periodic ticks with no software reload.

Software writes the 64-bit counter and compare values as two 32-bit halves. Reading the low counter word captures the high word in a shadow register, so that the next high-word read gives a torn-free 64-bit value. Write-status flags confirm that a write has landed. A flag rises one cycle after its write takes effect and stays set until software clears it by writing one to it.

Top module: `cmp_timer64`

## Requirements
- R1: After reset the counter, all compare values, steps, the control word, interrupt status and enables and all write-status flags are zero, and every interrupt line is low.
- R2: While control bit 8 (run) is set, the counter rises by one on every clock, carrying from the low half into the high half; while it is clear the counter holds its value.
- R3: A write to 0x100 loads the low 32 counter bits and a write to 0x104 loads the high 32 bits; the other half is untouched.
- R4: A read of 0x100 returns the live low word and captures the high word into a shadow; a read of 0x104 returns that shadow, not the live high word.
- R5: Channel n has its compare low word at 0x200+0x10·n, high word at +0x4 and step at +0x8; with control bit 2n (enable) set, a counter value equal to its compare value sets bit n of the status register at 0x244 on the next clock.
- R6: Writing a one to a bit of 0x244 clears that status bit; zero bits leave status unchanged.
- R7: Interrupt line n is high exactly when status bit n and bit n of the enable register at 0x248 are both set.
- R8: With control bit 2n+1 (rearm) also set, a match of channel n replaces its compare value by the old value plus the zero-extended step, modulo 2^64.
- R9: A write to counter word 0x100 or 0x104 sets bit 0 or bit 1 of 0x110 one clock after the write takes effect; writing one to a bit of 0x110 clears it.
- R10: Writes to compare low, high and step of channel n set bits 3n, 3n+1 and 3n+2 of 0x24C, and a control write sets bit 12, each one clock after the write takes effect; writing one to a bit of 0x24C clears it.
- R11: A channel whose enable bit is clear never sets its status bit, even when the counter passes its compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, acts on the rising edge |
| rdEn | input | 1 | Register read strobe, rdata is valid in the same cycle |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The bench counts exact clock cycles between the start and stop writes and then compares the final counter. An off-by-one in the start or stop edge, or a counter that runs while stopped, moves that value. It checks carry across the 32-bit boundary, and it checks a rearm step that wraps past 2^64. A design that drops the carry or truncates the sum reads back the wrong compare word. The bench reads the low word, rewrites the high word and then reads the high word, so a design that returns the live value instead of the shadow is caught. Write-status flags are read both in the cycle right after the write and one cycle later, which exposes a flag that rises too early or never. A disabled channel whose compare value the counter passes must stay silent in the status register.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int NUM_CMP  = 4;
  localparam int CNT_W    = 64;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int CH_W     = $clog2(NUM_CMP);
  localparam int CTRL_W   = 2 * NUM_CMP + 1;
  localparam int RUN_BIT  = 2 * NUM_CMP;
  localparam int WREG_W   = 3 * NUM_CMP + 1;
  localparam int CTRL_FLAG = 3 * NUM_CMP;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO   = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI   = 12'h104;
  localparam logic [ADDR_W-1:0] OFF_CNT_WST  = 12'h110;
  localparam logic [3:0]        CMP_PAGE     = 4'h2;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h240;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 12'h244;
  localparam logic [ADDR_W-1:0] OFF_INT_EN   = 12'h248;
  localparam logic [ADDR_W-1:0] OFF_REG_WST  = 12'h24C;

  typedef struct packed {
    logic               cntLoWr;
    logic               cntHiWr;
    logic [NUM_CMP-1:0] cmpLoWr;
    logic [NUM_CMP-1:0] cmpHiWr;
    logic [NUM_CMP-1:0] stepWr;
    logic               latchHi;
    logic               run;
    logic [NUM_CMP-1:0] cmpEn;
    logic [NUM_CMP-1:0] autoInc;
  } strobe_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           strb,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [CNT_W-1:0]                  cnt,
  output logic [WORD_W-1:0]                 cntHiShadow,
  output logic [NUM_CMP-1:0][CNT_W-1:0]     cmpVal,
  output logic [NUM_CMP-1:0][WORD_W-1:0]    stepVal,
  output logic [NUM_CMP-1:0]                match
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntLoWr) begin
      cnt <= {cnt[CNT_W-1:WORD_W], wdata};
    end else if (strb.cntHiWr) begin
      cnt <= {wdata, cnt[WORD_W-1:0]};
    end else if (strb.run) begin
      cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntHiShadow <= '0;
    else if (strb.latchHi) cntHiShadow <= cnt[CNT_W-1:WORD_W];
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : gChan
    assign match[g] = strb.cmpEn[g] && (cnt == cmpVal[g]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpVal[g] <= '0;
      end else if (strb.cmpLoWr[g]) begin
        cmpVal[g] <= {cmpVal[g][CNT_W-1:WORD_W], wdata};
      end else if (strb.cmpHiWr[g]) begin
        cmpVal[g] <= {wdata, cmpVal[g][WORD_W-1:0]};
      end else if (match[g] && strb.autoInc[g]) begin
        cmpVal[g] <= cmpVal[g] + {{(CNT_W-WORD_W){1'b0}}, stepVal[g]};
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) stepVal[g] <= '0;
      else if (strb.stepWr[g]) stepVal[g] <= wdata;
    end
  end
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic                              rdEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [WORD_W-1:0]                 wdata,
  input  logic [CNT_W-1:0]                  cnt,
  input  logic [WORD_W-1:0]                 cntHiShadow,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]     cmpVal,
  input  logic [NUM_CMP-1:0][WORD_W-1:0]    stepVal,
  input  logic [NUM_CMP-1:0]                match,
  output strobe_t                           strb,
  output logic [WORD_W-1:0]                 rdata,
  output logic [NUM_CMP-1:0]                intStatus,
  output logic [WREG_W-1:0]                 wstatReg,
  output logic [NUM_CMP-1:0]                irq
);
  logic [CTRL_W-1:0]  ctrlQ;
  logic [NUM_CMP-1:0] intEnQ;
  logic [1:0]         wstatCnt;
  logic [1:0]         pendCnt;
  logic [WREG_W-1:0]  pendReg;
  logic [WREG_W-1:0]  regWrNow;
  logic               inCmpPage;
  logic [CH_W-1:0]    chSel;
  logic               ctrlWr;

  assign inCmpPage = (addr[11:8] == CMP_PAGE) && (int'(addr[7:4]) < NUM_CMP);
  assign chSel     = addr[4+CH_W-1:4];
  assign ctrlWr    = wrEn && (addr == OFF_CTRL);

  always_comb begin
    strb         = '0;
    strb.cntLoWr = wrEn && (addr == OFF_CNT_LO);
    strb.cntHiWr = wrEn && (addr == OFF_CNT_HI);
    strb.latchHi = rdEn && (addr == OFF_CNT_LO);
    strb.run     = ctrlQ[RUN_BIT];
    for (int i = 0; i < NUM_CMP; i++) begin
      strb.cmpLoWr[i] = wrEn && inCmpPage && (chSel == CH_W'(i)) && (addr[3:0] == 4'h0);
      strb.cmpHiWr[i] = wrEn && inCmpPage && (chSel == CH_W'(i)) && (addr[3:0] == 4'h4);
      strb.stepWr[i]  = wrEn && inCmpPage && (chSel == CH_W'(i)) && (addr[3:0] == 4'h8);
      strb.cmpEn[i]   = ctrlQ[2*i];
      strb.autoInc[i] = ctrlQ[2*i+1];
    end
  end

  always_comb begin
    regWrNow = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      regWrNow[3*i]   = strb.cmpLoWr[i];
      regWrNow[3*i+1] = strb.cmpHiWr[i];
      regWrNow[3*i+2] = strb.stepWr[i];
    end
    regWrNow[CTRL_FLAG] = ctrlWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      intEnQ    <= '0;
      intStatus <= '0;
      pendCnt   <= '0;
      pendReg   <= '0;
      wstatCnt  <= '0;
      wstatReg  <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= wdata[CTRL_W-1:0];
      if (wrEn && addr == OFF_INT_EN) intEnQ <= wdata[NUM_CMP-1:0];
      intStatus <= (intStatus & ~((wrEn && addr == OFF_STATUS) ? wdata[NUM_CMP-1:0] : '0))
                   | match;
      pendCnt  <= {strb.cntHiWr, strb.cntLoWr};
      pendReg  <= regWrNow;
      wstatCnt <= (wstatCnt & ~((wrEn && addr == OFF_CNT_WST) ? wdata[1:0] : 2'b0)) | pendCnt;
      wstatReg <= (wstatReg & ~((wrEn && addr == OFF_REG_WST) ? wdata[WREG_W-1:0] : '0))
                  | pendReg;
    end
  end

  assign irq = intStatus & intEnQ;

  always_comb begin
    rdata = '0;
    if (inCmpPage) begin
      case (addr[3:0])
        4'h0:    rdata = cmpVal[chSel][WORD_W-1:0];
        4'h4:    rdata = cmpVal[chSel][CNT_W-1:WORD_W];
        4'h8:    rdata = stepVal[chSel];
        default: rdata = '0;
      endcase
    end else begin
      case (addr)
        OFF_CNT_LO:  rdata = cnt[WORD_W-1:0];
        OFF_CNT_HI:  rdata = cntHiShadow;
        OFF_CNT_WST: rdata = {{(WORD_W-2){1'b0}}, wstatCnt};
        OFF_CTRL:    rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrlQ};
        OFF_STATUS:  rdata = {{(WORD_W-NUM_CMP){1'b0}}, intStatus};
        OFF_INT_EN:  rdata = {{(WORD_W-NUM_CMP){1'b0}}, intEnQ};
        OFF_REG_WST: rdata = {{(WORD_W-WREG_W){1'b0}}, wstatReg};
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import cmp_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic [NUM_CMP-1:0]  irq
);
  strobe_t                           strb;
  logic [CNT_W-1:0]                  cnt;
  logic [WORD_W-1:0]                 cntHiShadow;
  logic [NUM_CMP-1:0][CNT_W-1:0]     cmpVal;
  logic [NUM_CMP-1:0][WORD_W-1:0]    stepVal;
  logic [NUM_CMP-1:0]                match;
  logic [NUM_CMP-1:0]                intStatus;
  logic [WREG_W-1:0]                 wstatReg;

  cmp_timer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .cnt(cnt), .cntHiShadow(cntHiShadow), .cmpVal(cmpVal), .stepVal(stepVal),
    .match(match), .strb(strb), .rdata(rdata), .intStatus(intStatus),
    .wstatReg(wstatReg), .irq(irq)
  );

  cmp_timer_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata), .cnt(cnt),
    .cntHiShadow(cntHiShadow), .cmpVal(cmpVal), .stepVal(stepVal), .match(match)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
(
  input logic                              clk,
  input logic                              rstN,
  input logic                              wrEn,
  input logic [ADDR_W-1:0]                 addr,
  input strobe_t                           strb,
  input logic [CNT_W-1:0]                  cnt,
  input logic [NUM_CMP-1:0][CNT_W-1:0]     cmpVal,
  input logic [NUM_CMP-1:0][WORD_W-1:0]    stepVal,
  input logic [NUM_CMP-1:0]                match,
  input logic [NUM_CMP-1:0]                intStatus,
  input logic [WREG_W-1:0]                 wstatReg
);
  a_r2_counts_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.cntLoWr && !strb.cntHiWr) |=> cnt == $past(cnt) + 64'd1);

  a_r2_holds_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.cntLoWr && !strb.cntHiWr) |=> $stable(cnt));

  a_r5_match_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    (|match) |=> ((intStatus & $past(match)) == $past(match)));

  a_r8_rearm_step: assert property (@(posedge clk) disable iff (!rstN)
    (match[0] && strb.autoInc[0] && !strb.cmpLoWr[0] && !strb.cmpHiWr[0])
    |=> cmpVal[0] == $past(cmpVal[0]) + {32'd0, $past(stepVal[0])});

  a_r10_ctrl_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_CTRL) |=> ##1 wstatReg[CTRL_FLAG]);
endmodule

bind cmp_timer64 cmp_timer_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb), .cnt(cnt),
  .cmpVal(cmpVal), .stepVal(stepVal), .match(match), .intStatus(intStatus),
  .wstatReg(wstatReg)
);

// File: tb/cmp_timer64_test.sv
module cmp_timer64_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [11:0] A_CLO = 12'h100, A_CHI = 12'h104, A_CWS = 12'h110;
  localparam logic [11:0] A_CTL = 12'h240, A_STS = 12'h244, A_IEN = 12'h248, A_RWS = 12'h24C;

  always #10 clk = ~clk;

  cmp_timer64 uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rdEn && expQ.size() > 0) check(tagQ.pop_front(), rdata, expQ.pop_front());
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #2;
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", {28'd0, irq}, 32'd0);
    busRd(A_CLO, 32'd0, "R1 counter low");
    busRd(A_CTL, 32'd0, "R1 control");
    busRd(A_RWS, 32'd0, "R1 write flags");
    // R3 / R9 counter load and its flag timing
    busWr(A_CLO, 32'd5);
    busRd(A_CWS, 32'd0, "R9 flag not yet set");
    busRd(A_CWS, 32'd1, "R9 flag set one cycle later");
    busWr(A_CWS, 32'd1);
    busRd(A_CWS, 32'd0, "R9 flag cleared");
    // R2 counting: start, 20 idle cycles, stop -> 21 increments
    busWr(A_CTL, 32'h100);
    idle(20);
    busWr(A_CTL, 32'h000);
    busRd(A_CLO, 32'd26, "R2 counted value");
    busRd(A_CHI, 32'd0, "R2 high word");
    idle(3);
    busRd(A_CLO, 32'd26, "R2 held while stopped");
    // R10 compare write flags
    busWr(A_RWS, 32'h1FFF);
    busRd(A_RWS, 32'd0, "R10 flags cleared");
    busWr(12'h214, 32'd0);
    busRd(A_RWS, 32'd0, "R10 flag not yet set");
    busRd(A_RWS, 32'h10, "R10 channel 1 high flag");
    busWr(A_RWS, 32'h10);
    // R5 R7 R8 R11 matching
    busWr(A_CLO, 32'd0);
    busWr(12'h200, 32'd10);
    busWr(12'h210, 32'd20);
    busWr(12'h220, 32'd15);
    busWr(12'h208, 32'd7);
    busWr(A_IEN, 32'h1);
    busWr(A_STS, 32'hF);
    busWr(A_CTL, 32'h107);
    idle(40);
    busWr(A_CTL, 32'h000);
    busRd(A_CLO, 32'd41, "R2 counter after match run");
    busRd(A_STS, 32'h3, "R5 R11 status channels 0,1 only");
    busRd(12'h200, 32'd45, "R8 rearmed compare value");
    busRd(12'h210, 32'd20, "R5 non-rearm compare unchanged");
    check("R7 irq enabled channel only", {28'd0, irq}, 32'h1);
    busWr(A_IEN, 32'h3);
    check("R7 irq both enabled", {28'd0, irq}, 32'h3);
    busWr(A_STS, 32'h1);
    busRd(A_STS, 32'h2, "R6 write-one clear");
    check("R7 irq after clear", {28'd0, irq}, 32'h2);
    // R2 carry across halves
    busWr(A_CLO, 32'hFFFF_FFFF);
    busWr(A_CHI, 32'd2);
    busWr(A_CTL, 32'h100);
    busWr(A_CTL, 32'h000);
    busRd(A_CLO, 32'd0, "R2 low after carry");
    busRd(A_CHI, 32'd3, "R2 high after carry");
    // R4 shadow
    busWr(A_CHI, 32'h55);
    busRd(A_CHI, 32'd3, "R4 shadow not live");
    busRd(A_CLO, 32'd0, "R4 low reread");
    busRd(A_CHI, 32'h55, "R4 shadow refreshed");
    // R8 wrap modulo 2^64
    busWr(A_STS, 32'hF);
    busWr(12'h200, 32'hFFFF_FFFE);
    busWr(12'h204, 32'hFFFF_FFFF);
    busWr(12'h208, 32'd5);
    busWr(A_CLO, 32'hFFFF_FFFE);
    busWr(A_CHI, 32'hFFFF_FFFF);
    busWr(A_CTL, 32'h103);
    busWr(A_CTL, 32'h000);
    busRd(12'h200, 32'd3, "R8 wrapped low");
    busRd(12'h204, 32'd0, "R8 wrapped high");
    busRd(A_STS, 32'h1, "R5 status after wrap match");
    busWr(A_CTL, 32'h0AA);
    busRd(A_CTL, 32'h0AA, "R5 control readback");
    idle(2);
    summary();
    $finish;
  end
endmodule